// File: doc/BRIEF.md
# Trapping Integer Execution Unit

This block is the single-cycle integer datapath of a 32-bit scalar core. It takes two register operands, an immediate shift amount, a bitfield position and width, and an operation select. It returns one result word, an overflow-trap flag and a write-enable for the destination register. There is no clock and no state. The pipeline registers its inputs and outputs around it.

The operations are:

- add and subtract, each in a wrapping form and in an overflow-trapping form;
- logical and arithmetic shifts;
- rotate right, with the amount taken from the immediate field or from a register;
- leading-zero and leading-one counts;
- field extract and field insert;
- swapping the bytes inside each halfword;
- sign extension of a byte or a halfword.

When a trapping form overflows, the destination write is withheld. The exception logic upstream uses the trap flag to redirect the core.

Top module: `int_exec_unit`

## Requirements
- R1: `OP_ADD` and `OP_SUB` return `op_a + op_b` and `op_a - op_b` modulo 2^32. They never raise `ovf_trap`.
- R2: `OP_ADDT` returns the wrapped sum. It raises `ovf_trap` exactly when `op_a` and `op_b` have equal sign bits and the sum's sign bit differs from them.
- R3: `OP_SUBT` returns the wrapped difference. It raises `ovf_trap` exactly when the sign bits of `op_a` and `op_b` differ and the difference's sign bit differs from that of `op_a`.
- R4: `wr_en` is low whenever `ovf_trap` is high, and high otherwise.
- R5: `OP_SLL`, `OP_SRL` and `OP_SRA` shift `op_a` by `shamt`. `OP_SRA` fills the vacated upper bits with bit 31 of `op_a`, and the other two fill them with zeros.
- R6: `OP_SLLV`, `OP_SRLV`, `OP_SRAV` and `OP_ROTRV` shift `op_a` by `op_b[4:0]`. Bits 31..5 of `op_b` have no effect on the result.
- R7: `OP_ROTR` (amount `shamt`) and `OP_ROTRV` return `(op_a >> n) | (op_a << (32-n))`. An amount of 0 returns `op_a` unchanged.
- R8: `OP_CLZ` returns the number of zero bits above the highest set bit of `op_a`, scanning from bit 31 down. It returns 32 for a zero operand.
- R9: `OP_CLO` returns the number of consecutive one bits of `op_a` starting at bit 31. It returns 32 for an all-ones operand.
- R10: `OP_EXT` returns `(op_a >> bf_pos)` masked to its low `bf_size` bits. A `bf_size` of 32 keeps every bit, and a `bf_size` of 0 returns 0.
- R11: `OP_INS` returns `op_b` with bits `bf_pos` to `bf_pos+bf_size-1` replaced by the low bits of `op_a`. All other bits of `op_b` are kept, field bits above bit 31 are dropped, and a `bf_size` of 0 returns `op_b`.
- R12: `OP_WSBH` exchanges byte 0 with byte 1 and byte 2 with byte 3 of `op_a`.
- R13: `OP_SEB` and `OP_SEH` copy bit 7 or bit 15 of `op_a` into every higher bit, keeping the low 8 or 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation select, one of the `iex_op_e` codes |
| op_a | input | 32 | First operand: addend, minuend, shift source, count source, field source |
| op_b | input | 32 | Second operand: addend, subtrahend, register shift amount, insert destination |
| shamt | input | 5 | Immediate shift or rotate amount |
| bf_pos | input | 5 | Lowest bit position of the field |
| bf_size | input | 6 | Field width in bits, 0 to 32 |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| wr_en | output | 1 | Destination register write enable |

## Verification
The bench builds two copies at `WIDTH=32`: one with the halving-tree leading counter (`LEAD_TREE=1`) and one with the linear scan (`LEAD_TREE=0`). Every vector is checked against both copies, so each counter variant is exercised on zero, all-ones and every single-bit position. The 32-bit width brings the signed-overflow boundaries, the 32-bit full-width field mask and every rotate amount from 0 to 31 within reach. The register-form rotate is driven with junk in the upper amount bits.

// File: rtl/iex_pkg.sv
package iex_pkg;
   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_ADDT  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBT  = 5'd3,
      OP_SLL   = 5'd4,
      OP_SRL   = 5'd5,
      OP_SRA   = 5'd6,
      OP_ROTR  = 5'd7,
      OP_SLLV  = 5'd8,
      OP_SRLV  = 5'd9,
      OP_SRAV  = 5'd10,
      OP_ROTRV = 5'd11,
      OP_CLZ   = 5'd12,
      OP_CLO   = 5'd13,
      OP_EXT   = 5'd14,
      OP_INS   = 5'd15,
      OP_WSBH  = 5'd16,
      OP_SEB   = 5'd17,
      OP_SEH   = 5'd18
   } iex_op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RLOG  = 2'd1,
      SH_RARI  = 2'd2,
      SH_ROT   = 2'd3
   } iex_shift_e;

   typedef enum logic [2:0] {
      BF_EXT  = 3'd0,
      BF_INS  = 3'd1,
      BF_SWAP = 3'd2,
      BF_SXB  = 3'd3,
      BF_SXH  = 3'd4
   } iex_bf_e;

   typedef enum logic [1:0] {
      GRP_ARITH = 2'd0,
      GRP_SHIFT = 2'd1,
      GRP_COUNT = 2'd2,
      GRP_FIELD = 2'd3
   } iex_grp_e;
endpackage

// File: rtl/iex_addsub.sv
module iex_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             subtract,
   input  logic             trap_en,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic             sign_clash;

   // Subtraction adds the one's complement plus a carry-in of one.
   assign b_eff = subtract ? ~b : b;
   assign sum   = a + b_eff + {{(WIDTH-1){1'b0}}, subtract};

   // The operands as seen by the adder agree in sign, yet the sum does not.
   assign sign_clash = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   assign ovf        = trap_en & sign_clash;
endmodule

// File: rtl/iex_shifter.sv
module iex_shifter
   import iex_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int SHW  = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] value,
   input  logic [SHW-1:0]   amt,
   input  iex_shift_e       kind,
   output logic [WIDTH-1:0] shifted
);
   logic [2*WIDTH-1:0] doubled;

   // A rotate is a right shift of the operand laid next to itself, so an
   // amount of zero never turns into a shift by the full width.
   assign doubled = {value, value} >> amt;

   always_comb begin
      unique case (kind)
         SH_LEFT: shifted = value << amt;
         SH_RLOG: shifted = value >> amt;
         SH_RARI: shifted = WIDTH'($signed(value) >>> amt);
         default: shifted = doubled[WIDTH-1:0];
      endcase
   end
endmodule

// File: rtl/iex_lead_count.sv
module iex_lead_count #(
   parameter int WIDTH     = 32,
   parameter bit LEAD_TREE = 1'b1,
   localparam int SHW      = $clog2(WIDTH),
   localparam int CW       = SHW + 1
) (
   input  logic [WIDTH-1:0] value,
   input  logic             count_ones,
   output logic [CW-1:0]    count
);
   logic [WIDTH-1:0] probe;

   // Counting leading ones is counting leading zeros of the complement.
   assign probe = count_ones ? ~value : value;

   generate
      if (LEAD_TREE) begin : g_tree
         always_comb begin
            logic [WIDTH-1:0] v;
            v     = probe;
            count = '0;
            for (int lvl = SHW - 1; lvl >= 0; lvl--) begin
               if ((v >> (WIDTH - (1 << lvl))) == '0) begin
                  count = count + CW'(1 << lvl);
                  v     = v << (1 << lvl);
               end
            end
            if (!v[WIDTH-1]) count = count + CW'(1);
         end
      end else begin : g_scan
         always_comb begin
            logic hit;
            hit   = 1'b0;
            count = '0;
            for (int i = WIDTH - 1; i >= 0; i--) begin
               if (!hit) begin
                  if (probe[i]) hit = 1'b1;
                  else          count = count + CW'(1);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/iex_bitfield.sv
module iex_bitfield
   import iex_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int SHW  = $clog2(WIDTH),
   localparam int NHW  = WIDTH / 16
) (
   input  logic [WIDTH-1:0] src,
   input  logic [WIDTH-1:0] dst,
   input  logic [SHW-1:0]   pos,
   input  logic [SHW:0]     size,
   input  iex_bf_e          mode,
   output logic [WIDTH-1:0] field_out
);
   logic [WIDTH-1:0] low_mask;
   logic [WIDTH-1:0] place_mask;
   logic [WIDTH-1:0] extracted;
   logic [WIDTH-1:0] inserted;
   logic [WIDTH-1:0] swapped;

   // A size equal to WIDTH shifts every one out, giving a full mask.
   assign low_mask   = ~({WIDTH{1'b1}} << size);
   assign place_mask = low_mask << pos;
   assign extracted  = (src >> pos) & low_mask;
   assign inserted   = (dst & ~place_mask) | ((src << pos) & place_mask);

   for (genvar h = 0; h < NHW; h++) begin : g_half
      assign swapped[h*16 +: 8]     = src[h*16+8 +: 8];
      assign swapped[h*16+8 +: 8]   = src[h*16 +: 8];
   end

   always_comb begin
      unique case (mode)
         BF_EXT:  field_out = extracted;
         BF_INS:  field_out = inserted;
         BF_SWAP: field_out = swapped;
         BF_SXB:  field_out = {{(WIDTH-8){src[7]}}, src[7:0]};
         default: field_out = {{(WIDTH-16){src[15]}}, src[15:0]};
      endcase
   end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import iex_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter bit LEAD_TREE = 1'b1,
   localparam int SHW      = $clog2(WIDTH),
   localparam int CW       = SHW + 1
) (
   input  logic [4:0]       op_sel,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [SHW-1:0]   shamt,
   input  logic [SHW-1:0]   bf_pos,
   input  logic [SHW:0]     bf_size,
   output logic [WIDTH-1:0] result,
   output logic             ovf_trap,
   output logic             wr_en
);
   generate
      if (WIDTH < 16 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("int_exec_unit: WIDTH must be a power of two of at least 16");
      end
   endgenerate

   iex_op_e          op;
   iex_grp_e         grp;
   iex_shift_e       sh_kind;
   iex_bf_e          bf_mode;
   logic             do_sub;
   logic             do_trap;
   logic             reg_amt;
   logic             want_ones;
   logic [SHW-1:0]   amount;
   logic [WIDTH-1:0] arith_res;
   logic [WIDTH-1:0] shift_res;
   logic [WIDTH-1:0] field_res;
   logic [CW-1:0]    lead_cnt;
   logic             arith_ovf;

   assign op = iex_op_e'(op_sel);

   always_comb begin
      grp       = GRP_ARITH;
      sh_kind   = SH_LEFT;
      bf_mode   = BF_EXT;
      do_sub    = 1'b0;
      do_trap   = 1'b0;
      reg_amt   = 1'b0;
      want_ones = 1'b0;
      unique case (op)
         OP_ADD:   ;
         OP_ADDT:  do_trap = 1'b1;
         OP_SUB:   do_sub  = 1'b1;
         OP_SUBT:  begin do_sub = 1'b1; do_trap = 1'b1; end
         OP_SLL:   grp = GRP_SHIFT;
         OP_SRL:   begin grp = GRP_SHIFT; sh_kind = SH_RLOG; end
         OP_SRA:   begin grp = GRP_SHIFT; sh_kind = SH_RARI; end
         OP_ROTR:  begin grp = GRP_SHIFT; sh_kind = SH_ROT;  end
         OP_SLLV:  begin grp = GRP_SHIFT; reg_amt = 1'b1; end
         OP_SRLV:  begin grp = GRP_SHIFT; sh_kind = SH_RLOG; reg_amt = 1'b1; end
         OP_SRAV:  begin grp = GRP_SHIFT; sh_kind = SH_RARI; reg_amt = 1'b1; end
         OP_ROTRV: begin grp = GRP_SHIFT; sh_kind = SH_ROT;  reg_amt = 1'b1; end
         OP_CLZ:   grp = GRP_COUNT;
         OP_CLO:   begin grp = GRP_COUNT; want_ones = 1'b1; end
         OP_EXT:   grp = GRP_FIELD;
         OP_INS:   begin grp = GRP_FIELD; bf_mode = BF_INS;  end
         OP_WSBH:  begin grp = GRP_FIELD; bf_mode = BF_SWAP; end
         OP_SEB:   begin grp = GRP_FIELD; bf_mode = BF_SXB;  end
         OP_SEH:   begin grp = GRP_FIELD; bf_mode = BF_SXH;  end
         default:  ;
      endcase
   end

   // Register-specified amounts keep only their low log2(WIDTH) bits.
   assign amount = reg_amt ? op_b[SHW-1:0] : shamt;

   iex_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a        (op_a),
      .b        (op_b),
      .subtract (do_sub),
      .trap_en  (do_trap),
      .sum      (arith_res),
      .ovf      (arith_ovf)
   );

   iex_shifter #(.WIDTH(WIDTH)) u_shifter (
      .value    (op_a),
      .amt      (amount),
      .kind     (sh_kind),
      .shifted  (shift_res)
   );

   iex_lead_count #(.WIDTH(WIDTH), .LEAD_TREE(LEAD_TREE)) u_lead (
      .value      (op_a),
      .count_ones (want_ones),
      .count      (lead_cnt)
   );

   iex_bitfield #(.WIDTH(WIDTH)) u_field (
      .src       (op_a),
      .dst       (op_b),
      .pos       (bf_pos),
      .size      (bf_size),
      .mode      (bf_mode),
      .field_out (field_res)
   );

   always_comb begin
      unique case (grp)
         GRP_ARITH: result = arith_res;
         GRP_SHIFT: result = shift_res;
         GRP_COUNT: result = WIDTH'(lead_cnt);
         default:   result = field_res;
      endcase
   end

   assign ovf_trap = arith_ovf;
   assign wr_en    = ~arith_ovf;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
   import iex_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int SHW  = $clog2(WIDTH)
) (
   input logic [4:0]       op_sel,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [SHW-1:0]   shamt,
   input logic [WIDTH-1:0] result,
   input logic             ovf_trap,
   input logic             wr_en
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      p_wr_blocked_r4: assert (!(ovf_trap && wr_en))
         else $error("write enabled during overflow trap");

      if (op_sel != OP_ADDT && op_sel != OP_SUBT) begin
         p_no_overflow_r1: assert (!ovf_trap)
            else $error("overflow flagged by a non-trapping op");
      end

      if (op_sel == OP_ADDT) begin
         p_addt_sign_r2: assert (ovf_trap ==
               ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])))
            else $error("trapping add overflow mismatch");
      end

      if (op_sel == OP_SUBT) begin
         p_subt_sign_r3: assert (ovf_trap ==
               ((op_a[MSB] != op_b[MSB]) && (result[MSB] != op_a[MSB])))
            else $error("trapping subtract overflow mismatch");
      end

      if (op_sel == OP_ROTR && shamt == '0) begin
         p_rot_zero_r7: assert (result == op_a)
            else $error("rotate by zero altered the operand");
      end

      if (op_sel == OP_ROTR || op_sel == OP_ROTRV) begin
         p_rot_perm_r7: assert ($countones(result) == $countones(op_a))
            else $error("rotate changed the number of set bits");
      end

      if (op_sel == OP_CLO && op_a == {WIDTH{1'b1}}) begin
         p_clo_full_r9: assert (result == WIDTH)
            else $error("leading-one count of all ones is not WIDTH");
      end

      if (op_sel == OP_WSBH) begin
         p_swap_perm_r12: assert ($countones(result) == $countones(op_a))
            else $error("halfword byte swap changed the set bits");
      end

      if (op_sel == OP_SEB) begin
         p_sext_byte_r13: assert (result[7:0] == op_a[7:0] &&
               (result[MSB:8] == '0 || result[MSB:8] == '1) &&
               result[8] == op_a[7])
            else $error("byte sign extension malformed");
      end
   end
endmodule

bind int_exec_unit int_exec_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .op_sel   (op_sel),
   .op_a     (op_a),
   .op_b     (op_b),
   .shamt    (shamt),
   .result   (result),
   .ovf_trap (ovf_trap),
   .wr_en    (wr_en)
);

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;
   import iex_pkg::*;

   typedef struct packed {
      iex_op_e     op;
      logic [31:0] a;
      logic [31:0] b;
      logic [4:0]  sh;
      logic [4:0]  pos;
      logic [5:0]  sz;
      logic [31:0] exp;
      logic        ovf;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 38;
   localparam vec_t VECS [NV] = '{
      '{OP_ADD,  32'h7FFFFFFF, 32'h00000001, 0, 0, 0, 32'h80000000, 1'b0, 1},  // R1
      '{OP_SUB,  32'h00000000, 32'h00000001, 0, 0, 0, 32'hFFFFFFFF, 1'b0, 1},  // R1
      '{OP_ADDT, 32'h7FFFFFFF, 32'h00000001, 0, 0, 0, 32'h80000000, 1'b1, 2},  // R2
      '{OP_ADDT, 32'h80000000, 32'h80000000, 0, 0, 0, 32'h00000000, 1'b1, 2},  // R2
      '{OP_ADDT, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 32'h7FFFFFFE, 1'b0, 2},  // R2
      '{OP_SUBT, 32'h80000000, 32'h00000001, 0, 0, 0, 32'h7FFFFFFF, 1'b1, 3},  // R3
      '{OP_SUBT, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 32'h80000000, 1'b1, 3},  // R3
      '{OP_SUBT, 32'h00000001, 32'hFFFFFFFF, 0, 0, 0, 32'h00000002, 1'b0, 3},  // R3
      '{OP_SUBT, 32'hFFFFFFFF, 32'h7FFFFFFF, 0, 0, 0, 32'h80000000, 1'b0, 3},  // R3
      '{OP_SLL,  32'h00000003, 32'h0,       31, 0, 0, 32'h80000000, 1'b0, 5},  // R5
      '{OP_SRL,  32'h80000000, 32'h0,        4, 0, 0, 32'h08000000, 1'b0, 5},  // R5
      '{OP_SRA,  32'h80000000, 32'h0,        4, 0, 0, 32'hF8000000, 1'b0, 5},  // R5
      '{OP_SLLV, 32'h00000001, 32'hFFFFFFE4, 0, 0, 0, 32'h00000010, 1'b0, 6},  // R6
      '{OP_SRAV, 32'h80000010, 32'h00000021, 0, 0, 0, 32'hC0000008, 1'b0, 6},  // R6
      '{OP_SRLV, 32'hF0000000, 32'h0000003F, 0, 0, 0, 32'h00000001, 1'b0, 6},  // R6
      '{OP_ROTR, 32'h12345678, 32'h0,        8, 0, 0, 32'h78123456, 1'b0, 7},  // R7
      '{OP_ROTR, 32'hDEADBEEF, 32'h0,        0, 0, 0, 32'hDEADBEEF, 1'b0, 7},  // R7
      '{OP_ROTRV,32'h80000001, 32'h00000021, 0, 0, 0, 32'hC0000000, 1'b0, 7},  // R7
      '{OP_ROTRV,32'hA5A5A5A5, 32'h00000020, 0, 0, 0, 32'hA5A5A5A5, 1'b0, 7},  // R7
      '{OP_CLZ,  32'h00000000, 32'h0,        0, 0, 0, 32'd32,       1'b0, 8},  // R8
      '{OP_CLZ,  32'h00010000, 32'h0,        0, 0, 0, 32'd15,       1'b0, 8},  // R8
      '{OP_CLZ,  32'h80000000, 32'h0,        0, 0, 0, 32'd0,        1'b0, 8},  // R8
      '{OP_CLO,  32'hFFFFFFFF, 32'h0,        0, 0, 0, 32'd32,       1'b0, 9},  // R9
      '{OP_CLO,  32'hFFF0FFFF, 32'h0,        0, 0, 0, 32'd12,       1'b0, 9},  // R9
      '{OP_CLO,  32'h7FFFFFFF, 32'h0,        0, 0, 0, 32'd0,        1'b0, 9},  // R9
      '{OP_EXT,  32'h12345678, 32'h0,        0, 8, 8, 32'h00000056, 1'b0, 10}, // R10
      '{OP_EXT,  32'h80000000, 32'h0,        0, 0,32, 32'h80000000, 1'b0, 10}, // R10
      '{OP_EXT,  32'hFFFFFFFF, 32'h0,        0,28, 8, 32'h0000000F, 1'b0, 10}, // R10
      '{OP_EXT,  32'hFFFFFFFF, 32'h0,        0, 3, 0, 32'h00000000, 1'b0, 10}, // R10
      '{OP_INS,  32'h000000AB, 32'h11111111, 0, 8, 8, 32'h1111AB11, 1'b0, 11}, // R11
      '{OP_INS,  32'hFFFFFFFF, 32'h00000000, 0,28, 8, 32'hF0000000, 1'b0, 11}, // R11
      '{OP_INS,  32'hCAFEF00D, 32'h12345678, 0, 0,32, 32'hCAFEF00D, 1'b0, 11}, // R11
      '{OP_INS,  32'hFFFFFFFF, 32'h12345678, 0, 4, 0, 32'h12345678, 1'b0, 11}, // R11
      '{OP_WSBH, 32'h11223344, 32'h0,        0, 0, 0, 32'h22114433, 1'b0, 12}, // R12
      '{OP_SEB,  32'h12345680, 32'h0,        0, 0, 0, 32'hFFFFFF80, 1'b0, 13}, // R13
      '{OP_SEB,  32'hFFFFFF7F, 32'h0,        0, 0, 0, 32'h0000007F, 1'b0, 13}, // R13
      '{OP_SEH,  32'h00008000, 32'h0,        0, 0, 0, 32'hFFFF8000, 1'b0, 13}, // R13
      '{OP_SEH,  32'hABCD1234, 32'h0,        0, 0, 0, 32'h00001234, 1'b0, 13}  // R13
   };

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op_sel  = 5'd0;
   logic [31:0] op_a    = 32'd0;
   logic [31:0] op_b    = 32'd0;
   logic [4:0]  shamt   = 5'd0;
   logic [4:0]  bf_pos  = 5'd0;
   logic [5:0]  bf_size = 6'd0;
   logic [31:0] res_t, res_l;
   logic        ovf_t, ovf_l, wr_t, wr_l;
   int          checks   = 0;
   int          failures = 0;
   bit          done     = 1'b0;

   always #4 clk = ~clk;

   int_exec_unit #(.WIDTH(32), .LEAD_TREE(1'b1)) u_dut (
      .op_sel (op_sel), .op_a (op_a), .op_b (op_b), .shamt (shamt),
      .bf_pos (bf_pos), .bf_size (bf_size),
      .result (res_t), .ovf_trap (ovf_t), .wr_en (wr_t)
   );

   int_exec_unit #(.WIDTH(32), .LEAD_TREE(1'b0)) u_dut_lin (
      .op_sel (op_sel), .op_a (op_a), .op_b (op_b), .shamt (shamt),
      .bf_pos (bf_pos), .bf_size (bf_size),
      .result (res_l), .ovf_trap (ovf_l), .wr_en (wr_l)
   );

   task automatic chk(input string tag, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic drive(input iex_op_e op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] sh,
                        input logic [4:0] pos, input logic [5:0] sz);
      @(posedge clk);
      op_sel  = op;
      op_a    = a;
      op_b    = b;
      shamt   = sh;
      bf_pos  = pos;
      bf_size = sz;
      @(negedge clk);
   endtask

   // R4: the write enable is the inverse of the expected trap in every check.
   task automatic chk_all(input string tag, input logic [31:0] exp_res,
                          input logic exp_ovf);
      chk({tag, " result(tree)"}, res_t, exp_res);
      chk({tag, " result(scan)"}, res_l, exp_res);
      chk({tag, " ovf(tree)"}, 32'(ovf_t), 32'(exp_ovf));
      chk({tag, " ovf(scan)"}, 32'(ovf_l), 32'(exp_ovf));
      chk({tag, " R4 wr_en(tree)"}, 32'(wr_t), 32'(!exp_ovf));
      chk({tag, " R4 wr_en(scan)"}, 32'(wr_l), 32'(!exp_ovf));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: with all inputs at zero during reset, a zero add writes zero.
      chk_all("R1 reset idle", 32'h0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sh, VECS[i].pos,
               VECS[i].sz);
         chk_all($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp,
                 VECS[i].ovf);
      end

      // R7 and R6: every rotate amount, upper amount bits set to junk.
      for (int n = 0; n < 32; n++) begin
         logic [31:0] x, e;
         x = 32'h8000_00F1;
         e = (n == 0) ? x : ((x >> n) | (x << (32 - n)));
         drive(OP_ROTRV, x, 32'hFFFF_FFE0 | 32'(n), 5'd0, 5'd0, 6'd0);
         chk_all($sformatf("R7 R6 rotrv n=%0d", n), e, 1'b0);
      end

      // R8 and R9: single-bit patterns across every position.
      for (int i = 0; i < 32; i++) begin
         drive(OP_CLZ, 32'h1 << i, 32'h0, 5'd0, 5'd0, 6'd0);
         chk_all($sformatf("R8 clz bit%0d", i), 32'(31 - i), 1'b0);
         drive(OP_CLO, ~(32'h1 << i), 32'h0, 5'd0, 5'd0, 6'd0);
         chk_all($sformatf("R9 clo bit%0d", i), 32'(31 - i), 1'b0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule